// File: doc/BRIEF.md
# PCM Serial Audio Output Formatter

The formatter accepts decoded stereo samples and sends them out one bit at a time on a three-wire PCM link: serial data, a bit clock and a channel clock that is low for the left channel and high for the right. The bit clock comes from a master clock-enable pulse, `tick`: every pulse toggles the bit clock, so one bit lasts two pulses. Data and channel clock change only on the falling bit-clock edge, and a receiver samples on the rising edge.

The word width, the bit order and the slot length are set on configuration inputs. So are, in long slots, the placement of the word and the value of the spare bit positions. A play/mute pair gates the stream. The configuration inputs are meant to be changed while `rst_n` is low. A stereo pair is taken through a valid/ready handshake at the start of every left slot. When the source has nothing ready at that point, the previous pair is sent again.

The slot sequencer has three states. `ST_IDLE` is entered at reset. The first tick moves it to `ST_LEFT` (transition *start*). At the last bit of a slot, a launch moves `ST_LEFT` to `ST_RIGHT` (transition *to_right*) and `ST_RIGHT` back to `ST_LEFT` (transition *to_left*). Any other launch stays in the same state and advances the bit index (transition *next_bit*). A launch is a tick that comes while the bit clock is high, or the first tick after `ST_IDLE`.

Top module: `pcm_out_fmt`

## Requirements
- R1: While `rst_n` is low and until the first tick after it, `pcm_bclk`, `pcm_lrck`, `pcm_sdo` and `s_ready` are 0.
- R2: After the first tick, every tick toggles `pcm_bclk`. `pcm_sdo` changes only in a cycle where `pcm_bclk` is low, and each bit is held for two ticks.
- R3: `pcm_lrck` is 0 during left slots and 1 during right slots. The first slot after reset is a left slot. A slot is 32 bits when `cfg_slot32`=1 and 16 bits when it is 0.
- R4: `cfg_prec` selects the word length from the sample's most significant bits: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24 of the 24 sample bits.
- R5: `cfg_lsb_first`=0 sends the word most significant bit first. `cfg_lsb_first`=1 sends its least significant bit first.
- R6: In 32-bit slots, `cfg_rjust`=0 places the word at slot bit 0 with padding after it. `cfg_rjust`=1 places the padding first, so the word ends on the last slot bit.
- R7: Padding bits are 0 when `cfg_signpad`=0. When `cfg_signpad`=1 they repeat sample bit 23.
- R8: In 16-bit slots, a word longer than 16 bits is cut to its 16 most significant bits, which are then sent in the selected order.
- R9: `s_ready` is high only in the cycle that launches bit 0 of a left slot. A pair is accepted when `s_valid` is also high, and its left word is sent in that very slot.
- R10: When a left slot starts without `s_valid`, the previously accepted pair is sent again on both channels.
- R11: A bit launched while `play`=0 or `mute`=1 is sent as 0. Real bits go out only when `play`=1 and `mute`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable; each pulse toggles the bit clock |
| cfg_prec | input | 2 | Word length code (16/18/20/24) |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_slot32 | input | 1 | 1 = 32-bit slots, 0 = 16-bit slots |
| cfg_rjust | input | 1 | 1 = word at the end of a long slot |
| cfg_signpad | input | 1 | 1 = padding copies the sign bit |
| play | input | 1 | Play enable |
| mute | input | 1 | Mute |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Sample pair taken this cycle |
| s_left | input | 24 | Left sample |
| s_right | input | 24 | Right sample |
| pcm_bclk | output | 1 | Serial bit clock |
| pcm_lrck | output | 1 | Channel clock, 0 = left |
| pcm_sdo | output | 1 | Serial data |

## Verification
A wrong slot state or bit index shows on `pcm_lrck` as a slot of the wrong length, or as a data bit taken from the wrong sample position. Either becomes visible within one slot, at most 32 bit periods. A hold register that loads at the wrong moment shows as a wrong or missing repeat within one frame. A wrong alignment or padding choice corrupts the bits around the word boundary of the very first slot. The bench compares every slot bit by bit with a model fed from the accepted pairs, so each of these faults is caught in the slot where it occurs.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } slot_state_t;

    // word length for each precision code
    function automatic logic [5:0] prec_width(input logic [1:0] code);
        logic [5:0] w;
        unique case (code)
            2'd0: w = 6'd16;
            2'd1: w = 6'd18;
            2'd2: w = 6'd20;
            default: w = 6'd24;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pcm_slot_fsm.sv
module pcm_slot_fsm
    import pcm_fmt_pkg::*;
#(
    parameter int SLOT_LONG  = 32,
    parameter int SLOT_SHORT = 16,
    localparam int CNT_W     = $clog2(SLOT_LONG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             slot32,
    output logic             bclk_o,
    output logic             lrck_o,
    output logic             launch_o,
    output logic             start_left_o,
    output logic             right_o,
    output logic [CNT_W-1:0] idx_o
);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(SLOT_LONG - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SLOT_SHORT - 1);

    slot_state_t      state, nstate;
    logic [CNT_W-1:0] cnt, ncnt;
    logic [CNT_W-1:0] last;
    logic             launch;

    assign last   = slot32 ? LAST_LONG : LAST_SHORT;
    assign launch = tick && ((state == ST_IDLE) || bclk_o);

    always_comb begin
        nstate = state;
        ncnt   = cnt;
        if (launch) begin
            unique case (state)
                ST_IDLE: begin
                    nstate = ST_LEFT;
                    ncnt   = '0;
                end
                ST_LEFT: begin
                    if (cnt == last) begin
                        nstate = ST_RIGHT;
                        ncnt   = '0;
                    end else begin
                        ncnt = cnt + 1'b1;
                    end
                end
                ST_RIGHT: begin
                    if (cnt == last) begin
                        nstate = ST_LEFT;
                        ncnt   = '0;
                    end else begin
                        ncnt = cnt + 1'b1;
                    end
                end
                default: begin
                    nstate = ST_IDLE;
                    ncnt   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_o <= 1'b0;
            lrck_o <= 1'b0;
        end else begin
            if (tick && (state != ST_IDLE)) bclk_o <= ~bclk_o;
            if (launch) lrck_o <= (nstate == ST_RIGHT);
        end
    end

    assign launch_o     = launch;
    assign idx_o        = ncnt;
    assign right_o      = (nstate == ST_RIGHT);
    assign start_left_o = launch && (nstate == ST_LEFT) && (ncnt == '0);

endmodule

// File: rtl/pcm_sample_hold.sv
module pcm_sample_hold #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_start,
    input  logic                sel_right,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                s_ready,
    output logic [SAMPLE_W-1:0] word_o
);
    logic [SAMPLE_W-1:0] hold_l, hold_r;
    logic                take;

    assign s_ready = slot_start;
    assign take    = slot_start && s_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (take) begin
            hold_l <= s_left;
            hold_r <= s_right;
        end
    end

    assign word_o = sel_right ? hold_r : (take ? s_left : hold_l);

endmodule

// File: rtl/pcm_bit_select.sv
module pcm_bit_select
    import pcm_fmt_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int SLOT_LONG  = 32,
    parameter int SLOT_SHORT = 16,
    localparam int CNT_W     = $clog2(SLOT_LONG),
    localparam int IW        = CNT_W + 1,
    localparam int BW        = $clog2(SAMPLE_W)
) (
    input  logic [SAMPLE_W-1:0] word,
    input  logic [CNT_W-1:0]    idx,
    input  logic [1:0]          prec,
    input  logic                slot32,
    input  logic                lsb_first,
    input  logic                rjust,
    input  logic                sign_pad,
    output logic                bit_o
);
    logic [IW-1:0] pw, sl, len, pad, pos, w, src;
    logic          in_word;

    always_comb begin
        pw  = IW'(prec_width(prec));
        sl  = slot32 ? IW'(SLOT_LONG) : IW'(SLOT_SHORT);
        len = (pw < sl) ? pw : sl;
        pad = sl - len;
        pos = {1'b0, idx};
        if (rjust) begin
            in_word = (pos >= pad);
            w       = in_word ? (pos - pad) : '0;
        end else begin
            in_word = (pos < len);
            w       = in_word ? pos : '0;
        end
        src = lsb_first ? (IW'(SAMPLE_W) - len + w) : (IW'(SAMPLE_W - 1) - w);
        bit_o = in_word ? word[src[BW-1:0]] : (sign_pad & word[SAMPLE_W-1]);
    end

endmodule

// File: rtl/pcm_out_fmt.sv
module pcm_out_fmt #(
    parameter int SAMPLE_W   = 24,
    parameter int SLOT_LONG  = 32,
    parameter int SLOT_SHORT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [1:0]          cfg_prec,
    input  logic                cfg_lsb_first,
    input  logic                cfg_slot32,
    input  logic                cfg_rjust,
    input  logic                cfg_signpad,
    input  logic                play,
    input  logic                mute,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                pcm_bclk,
    output logic                pcm_lrck,
    output logic                pcm_sdo
);
    localparam int CNT_W = $clog2(SLOT_LONG);

    logic                launch, start_left, sel_right, nbit;
    logic [CNT_W-1:0]    idx;
    logic [SAMPLE_W-1:0] word;

    pcm_slot_fsm #(.SLOT_LONG(SLOT_LONG), .SLOT_SHORT(SLOT_SHORT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .slot32(cfg_slot32),
        .bclk_o(pcm_bclk), .lrck_o(pcm_lrck), .launch_o(launch),
        .start_left_o(start_left), .right_o(sel_right), .idx_o(idx)
    );

    pcm_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .slot_start(start_left), .sel_right(sel_right),
        .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
        .s_ready(s_ready), .word_o(word)
    );

    pcm_bit_select #(.SAMPLE_W(SAMPLE_W), .SLOT_LONG(SLOT_LONG), .SLOT_SHORT(SLOT_SHORT)) u_sel (
        .word(word), .idx(idx), .prec(cfg_prec), .slot32(cfg_slot32),
        .lsb_first(cfg_lsb_first), .rjust(cfg_rjust), .sign_pad(cfg_signpad),
        .bit_o(nbit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      pcm_sdo <= 1'b0;
        else if (launch) pcm_sdo <= (play && !mute) ? nbit : 1'b0;
    end

endmodule

// File: rtl/pcm_out_fmt_chk.sv
module pcm_out_fmt_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic play,
    input logic mute,
    input logic s_ready,
    input logic pcm_bclk,
    input logic pcm_lrck,
    input logic pcm_sdo
);
    // R2: data moves only with the bit clock low
    a_r2_sdo_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pcm_sdo) |-> !pcm_bclk);

    // R2: the bit clock moves only on a tick
    a_r2_bclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pcm_bclk) |-> $past(tick));

    // R3: channel clock moves only with the bit clock low
    a_r3_lrck_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pcm_lrck) |-> !pcm_bclk);

    // R9: acceptance coincides with a tick and opens a left slot
    a_r9_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> tick);

    a_r9_ready_left: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !pcm_lrck);

    // R11: a one can only appear if the stream was open
    a_r11_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_sdo) |-> $past(play && !mute));

endmodule

bind pcm_out_fmt pcm_out_fmt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .play(play), .mute(mute),
    .s_ready(s_ready), .pcm_bclk(pcm_bclk), .pcm_lrck(pcm_lrck), .pcm_sdo(pcm_sdo)
);

// File: tb/pcm_out_fmt_test.sv
module pcm_out_fmt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  c_prec = 2'd3;
    logic        c_lsb = 1'b0, c_slot32 = 1'b1, c_rjust = 1'b0, c_signpad = 1'b0;
    logic        c_play = 1'b1, c_mute = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [23:0] s_left = '0, s_right = '0;
    logic        pcm_bclk, pcm_lrck, pcm_sdo;

    int checks = 0, errors = 0;
    bit done = 0;
    bit gap_on = 0;
    int slots_seen = 0;
    int accepted = 0;
    int target_slots = 0;
    string label = "";
    logic [47:0] q[$];

    always #4 clk = ~clk;

    pcm_out_fmt uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_prec(c_prec),
        .cfg_lsb_first(c_lsb), .cfg_slot32(c_slot32), .cfg_rjust(c_rjust),
        .cfg_signpad(c_signpad), .play(c_play), .mute(c_mute),
        .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .pcm_bclk(pcm_bclk), .pcm_lrck(pcm_lrck), .pcm_sdo(pcm_sdo)
    );

    function automatic logic expbit(logic [23:0] smp, int k);
        int pw, sl, len, pad, w;
        bit inw;
        pw  = (c_prec == 0) ? 16 : (c_prec == 1) ? 18 : (c_prec == 2) ? 20 : 24;
        sl  = c_slot32 ? 32 : 16;
        len = (pw < sl) ? pw : sl;
        pad = sl - len;
        if (c_mute || !c_play) return 1'b0;
        if (c_rjust) begin inw = (k >= pad); w = k - pad; end
        else         begin inw = (k < len);  w = k;       end
        if (!inw) return c_signpad ? smp[23] : 1'b0;
        return c_lsb ? smp[24 - len + w] : smp[23 - w];
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // driver: tick generation and sample handshake, pushes accepted pairs
    initial begin
        bit hs_pend = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                tick = 1'b0; s_valid = 1'b0; hs_pend = 0;
            end else begin
                if (hs_pend) begin
                    s_left  = 24'($urandom);
                    s_right = 24'($urandom);
                    hs_pend = 0;
                end
                tick    = ~tick;
                s_valid = !(gap_on && slots_seen >= 2 && slots_seen < 6);
                #1;
                if (s_valid && s_ready) begin
                    q.push_back({s_left, s_right});
                    if (slots_seen < target_slots) accepted++;
                    hs_pend = 1;
                end
            end
        end
    end

    // monitor: collects slots at rising bit clock and compares with the model
    initial begin
        bit prev = 0, have_rise = 0, ch = 0, per_bad = 0, lr_bad = 0;
        int idx = 0, gapc = 0, sl;
        logic [23:0] cur_l = '0, cur_r = '0;
        logic [31:0] got, exp;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev = 0; have_rise = 0; ch = 0; idx = 0; gapc = 0;
                per_bad = 0; lr_bad = 0; cur_l = '0; cur_r = '0;
                got = '0; exp = '0; slots_seen = 0;
            end else begin
                gapc++;
                if (pcm_bclk && !prev) begin
                    sl = c_slot32 ? 32 : 16;
                    if (idx == 0 && !ch && q.size() > 0) {cur_l, cur_r} = q.pop_front();
                    if (have_rise && gapc != 4) per_bad = 1;
                    gapc = 0; have_rise = 1;
                    if (pcm_lrck !== ch) lr_bad = 1;
                    got[idx] = pcm_sdo;
                    exp[idx] = expbit(ch ? cur_r : cur_l, idx);
                    idx++;
                    if (idx == sl) begin
                        check(got === exp, $sformatf("%s slot %0d bits", label, slots_seen), got, exp);
                        check(!lr_bad, $sformatf("R3 slot %0d lrck", slots_seen), 32'(lr_bad), 32'd0);
                        check(!per_bad, $sformatf("R2 slot %0d bit period", slots_seen), 32'(per_bad), 32'd0);
                        got = '0; exp = '0; idx = 0; ch = ~ch;
                        lr_bad = 0; per_bad = 0;
                        slots_seen++;
                    end
                end
                prev = pcm_bclk;
            end
        end
    end

    task automatic run_seg(string tag, logic [1:0] prec, bit lsb, bit s32, bit rj,
                           bit sp, bit pl, bit mu, bit gap, int frames);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        c_prec = prec; c_lsb = lsb; c_slot32 = s32; c_rjust = rj;
        c_signpad = sp; c_play = pl; c_mute = mu; gap_on = gap;
        label = tag; accepted = 0; target_slots = 2 * frames;
        q.delete();
        @(negedge clk);
        check({pcm_bclk, pcm_lrck, pcm_sdo, s_ready} === 4'b0, "R1 reset outputs",
              32'({pcm_bclk, pcm_lrck, pcm_sdo, s_ready}), 32'd0);
        rst_n = 1'b1;
        while (slots_seen < 2 * frames) @(negedge clk);
        if (gap)
            check(accepted == frames - 2, "R9 accepted pairs", 32'(accepted), 32'(frames - 2));
        else
            check(accepted == frames, "R9 accepted pairs", 32'(accepted), 32'(frames));
    endtask

    initial begin
        run_seg("R4 R6 msb24",        2'd3, 0, 1, 0, 0, 1, 0, 0, 6);
        run_seg("R5 R6 R7 rj16 sign", 2'd0, 1, 1, 1, 1, 1, 0, 0, 6);
        run_seg("R4 R6 rj18 zero",    2'd1, 0, 1, 1, 0, 1, 0, 0, 6);
        run_seg("R4 R5 R7 lj20 sign", 2'd2, 1, 1, 0, 1, 1, 0, 0, 6);
        run_seg("R8 trunc24 msb",     2'd3, 0, 0, 0, 0, 1, 0, 0, 6);
        run_seg("R5 R8 trunc20 lsb",  2'd2, 1, 0, 0, 1, 1, 0, 0, 6);
        run_seg("R11 muted",          2'd3, 0, 1, 0, 1, 1, 1, 0, 4);
        run_seg("R11 stopped",        2'd3, 1, 1, 1, 1, 0, 0, 0, 4);
        run_seg("R10 repeat",         2'd3, 0, 1, 0, 0, 1, 0, 1, 6);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule